// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register side of a bank of general-purpose pins. A simple word-wide bus (byte address, write data, write strobe, combinational read data) reaches two kinds of storage: bitmapped words, where each 32-bit word covers 32 pins and the word for pin n sits at the group base plus (n/32)*4, and a pair of per-pin configuration words laid out back to back at a stride of 8 bytes starting at offset 0x100.

From that storage the block drives each pin's output level and output enable and exports each pin's pull option, use-select bit, trigger controls and interrupt enable. It also hands a gated copy of each pad input to a separate interrupt detector. Pad inputs pass through a two-flop synchronizer. The synchronized level reads back in configuration word 1 and is passed on only while input sensing is enabled. Event pulses from the detector latch into a status bitmap, which software clears by writing ones. A read-only ownership bitmap, loaded at reset from a parameter, tells software which pins it may use.

Top module: `gpio_bank_regs`

## Requirements
- R1: The ownership bitmap at offset 0x00 resets to the OWN_INIT parameter and ignores writes. Bit n%32 of the word at 0x00+(n/32)*4 is 1 when pin n is available to software and 0 when it is reserved.
- R2: The global control word at 0x7C is a 32-bit read/write register that resets to 0 and appears on gctl_q.
- R3: The interrupt enable bitmap at 0x90 holds one bit per pin (bit n%32 of word 0x90+(n/32)*4), resets to 0, is read/write, and drives irq_en.
- R4: Configuration word 1 of pin n sits at 0x100+8*n. Its stored fields are output level (bit 31), trigger select (bit 4, 0 edge, 1 level), trigger invert (bit 3), direction (bit 2, 0 output, 1 input) and use select (bit 0, 0 native, 1 GPIO). All other bits except bit 30 read 0, and the reset value is 0x00000004.
- R5: Configuration word 2 of pin n sits at 0x104+8*n. It holds the input-sense disable (bit 2) and the pull option (bits 1:0), reads 0 in its other bits, and resets to 0x00000004.
- R6: Bit 30 of configuration word 1 reads the pad input after two synchronizer flops. It reads 0 while input sensing is disabled, and writes to it have no effect. det_in carries the same gated value.
- R7: pad_out follows the output-level bit. pad_oe is 1 only when direction is 0 and use select is 1. trig_level, trig_inv, pin_use and pin_pull follow their stored fields.
- R8: The status bitmap at 0x80 (bit n%32 of word 0x80+(n/32)*4) sets a pin's bit one cycle after its irq_event is high. Writing a 1 to a bit clears it. An event in the same cycle as the clearing write leaves the bit set.
- R9: Reads of unmapped offsets, of offsets not aligned to a word, of bitmap words past the pin count, and of configuration words for pins at or above NUM_PINS return 0. Writes to them change nothing. Bitmap bits for pins at or above NUM_PINS read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Output level per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pin_use | output | NUM_PINS | Use select per pin (1 GPIO) |
| pin_pull | output | 2*NUM_PINS | Pull option, two bits per pin |
| trig_level | output | NUM_PINS | Trigger select per pin (1 level) |
| trig_inv | output | NUM_PINS | Trigger invert per pin |
| irq_en | output | NUM_PINS | Interrupt enable per pin |
| det_in | output | NUM_PINS | Synchronized, sense-gated input to the detector |
| irq_event | input | NUM_PINS | Event pulses from the detector |
| gctl_q | output | 32 | Global control word |

## Verification
The bench builds the block with NUM_PINS set to 40 and a mixed OWN_INIT pattern. This leaves the second bitmap word only partly populated and the third word past the bank entirely. Pin 40's configuration pair becomes the first out-of-range address, reachable among random addresses alongside the mapped ones. The 12-bit default address width keeps the whole map, including misaligned and unmapped holes, within the random address draw. Directed cases cover the two-cycle synchronizer latency, the clear/set race on the status bits and output-enable gating.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned WORD_W = 32;

  // byte offsets of the register groups
  localparam int unsigned OFS_OWN  = 'h000;
  localparam int unsigned OFS_GCTL = 'h07C;
  localparam int unsigned OFS_STAT = 'h080;
  localparam int unsigned OFS_EN   = 'h090;
  localparam int unsigned OFS_CFG  = 'h100;
  localparam int unsigned CFG_STRIDE = 8;

  // bit positions, configuration word 1
  localparam int unsigned B1_OUT  = 31;
  localparam int unsigned B1_IN   = 30;
  localparam int unsigned B1_TRIG = 4;
  localparam int unsigned B1_INV  = 3;
  localparam int unsigned B1_DIR  = 2;
  localparam int unsigned B1_USE  = 0;
  // bit positions, configuration word 2
  localparam int unsigned B2_SDIS = 2;

  typedef struct packed {
    logic out_lvl;
    logic trig_lvl;
    logic trig_inv;
    logic dir_in;
    logic use_gpio;
  } cfg1_t;

  typedef struct packed {
    logic       sense_dis;
    logic [1:0] pull;
  } cfg2_t;

  typedef enum logic [2:0] {
    RG_NONE, RG_OWN, RG_GCTL, RG_STAT, RG_EN, RG_CFG1, RG_CFG2
  } reg_sel_e;

  localparam cfg1_t CFG1_RST = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                                  dir_in: 1'b1, use_gpio: 1'b0};
  localparam cfg2_t CFG2_RST = '{sense_dis: 1'b1, pull: 2'b00};

  function automatic int unsigned bitmap_words(int unsigned pins);
    return (pins + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int unsigned idx_width(int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

  function automatic cfg1_t unpack_cfg1(logic [WORD_W-1:0] w);
    cfg1_t c;
    c.out_lvl  = w[B1_OUT];
    c.trig_lvl = w[B1_TRIG];
    c.trig_inv = w[B1_INV];
    c.dir_in   = w[B1_DIR];
    c.use_gpio = w[B1_USE];
    return c;
  endfunction

  function automatic cfg2_t unpack_cfg2(logic [WORD_W-1:0] w);
    cfg2_t c;
    c.sense_dis = w[B2_SDIS];
    c.pull      = w[1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cfg1(cfg1_t c, logic in_lvl);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B1_OUT]  = c.out_lvl;
    w[B1_IN]   = in_lvl;
    w[B1_TRIG] = c.trig_lvl;
    w[B1_INV]  = c.trig_inv;
    w[B1_DIR]  = c.dir_in;
    w[B1_USE]  = c.use_gpio;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cfg2(cfg2_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B2_SDIS] = c.sense_dis;
    w[1:0]     = c.pull;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 94,
  parameter int unsigned ADDR_W   = 12,
  localparam int unsigned NWORDS  = bitmap_words(NUM_PINS),
  localparam int unsigned WIDX_W  = idx_width(NWORDS),
  localparam int unsigned PIN_W   = idx_width(NUM_PINS)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [WIDX_W-1:0] word_idx,
  output logic [PIN_W-1:0]  pin_idx
);
  int unsigned av;
  int unsigned pin_n;
  int unsigned word_n;

  always_comb begin
    av       = int'(addr);
    sel      = RG_NONE;
    word_n   = 0;
    pin_n    = 0;
    if (av[1:0] == 2'b00) begin
      if (av >= OFS_CFG) begin
        pin_n = (av - OFS_CFG) / CFG_STRIDE;
        if (pin_n < NUM_PINS)
          sel = av[2] ? RG_CFG2 : RG_CFG1;
      end else if (av == OFS_GCTL) begin
        sel = RG_GCTL;
      end else if (av < OFS_OWN + 4*NWORDS) begin
        sel    = RG_OWN;
        word_n = (av - OFS_OWN) / 4;
      end else if (av >= OFS_STAT && av < OFS_STAT + 4*NWORDS) begin
        sel    = RG_STAT;
        word_n = (av - OFS_STAT) / 4;
      end else if (av >= OFS_EN && av < OFS_EN + 4*NWORDS) begin
        sel    = RG_EN;
        word_n = (av - OFS_EN) / 4;
      end
    end
    word_idx = WIDX_W'(word_n);
    pin_idx  = PIN_W'(pin_n);
  end
endmodule

// File: rtl/gpio_bitmap_bank.sv
module gpio_bitmap_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 94,
  parameter bit          CLEAR_ON_ONE = 1'b0,
  localparam int unsigned NWORDS      = bitmap_words(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NWORDS-1:0]   wr_word,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] set_bits,
  output logic [NUM_PINS-1:0] q
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    localparam int unsigned W = i / WORD_W;
    localparam int unsigned B = i % WORD_W;
    logic nxt;
    if (CLEAR_ON_ONE) begin : g_w1c
      // set takes priority over a clear in the same cycle
      assign nxt = (q[i] & ~(wr_word[W] & wdata[B])) | set_bits[i];
    end else begin : g_rw
      assign nxt = (wr_word[W] ? wdata[B] : q[i]) | set_bits[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt;
    end
  end
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr1,
  input  logic              wr2,
  input  cfg1_t             new1,
  input  cfg2_t             new2,
  input  logic              sync_in,
  output cfg1_t             c1,
  output cfg2_t             c2,
  output logic              in_lvl,
  output logic [WORD_W-1:0] rd1,
  output logic [WORD_W-1:0] rd2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= CFG1_RST;
      c2 <= CFG2_RST;
    end else begin
      if (wr1) c1 <= new1;
      if (wr2) c2 <= new2;
    end
  end

  assign in_lvl = sync_in & ~c2.sense_dis;
  assign rd1    = pack_cfg1(c1, in_lvl);
  assign rd2    = pack_cfg2(c2);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 94,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [127:0] OWN_INIT = '1,
  localparam int unsigned NWORDS  = bitmap_words(NUM_PINS),
  localparam int unsigned WIDX_W  = idx_width(NWORDS),
  localparam int unsigned PIN_W   = idx_width(NUM_PINS),
  localparam int unsigned PAD_W   = NWORDS * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  input  logic                  bus_we,
  output logic [WORD_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pin_use,
  output logic [2*NUM_PINS-1:0] pin_pull,
  output logic [NUM_PINS-1:0]   trig_level,
  output logic [NUM_PINS-1:0]   trig_inv,
  output logic [NUM_PINS-1:0]   irq_en,
  output logic [NUM_PINS-1:0]   det_in,
  input  logic [NUM_PINS-1:0]   irq_event,
  output logic [WORD_W-1:0]     gctl_q
);
  // status/enable groups must not overlap: at most four words each
  initial if (NUM_PINS < 1 || NWORDS > 4)
    $error("gpio_bank_regs: NUM_PINS must lie in 1..128");

  reg_sel_e           sel;
  logic [WIDX_W-1:0]  word_idx;
  logic [PIN_W-1:0]   pin_idx;
  logic               addr_hit;
  logic [NUM_PINS-1:0] own_q;
  logic [NUM_PINS-1:0] stat_q;
  logic [NUM_PINS-1:0] sync_q;
  logic [NWORDS-1:0]  wr_stat, wr_en;
  logic [PAD_W-1:0]   own_pad, stat_pad, en_pad;
  logic [WORD_W-1:0]  rd1 [NUM_PINS];
  logic [WORD_W-1:0]  rd2 [NUM_PINS];
  cfg1_t              wcfg1;
  cfg2_t              wcfg2;

  gpio_addr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(sel), .word_idx(word_idx), .pin_idx(pin_idx)
  );
  assign addr_hit = (sel != RG_NONE);

  gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
  );

  // ownership: loaded at reset, never written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_INIT[NUM_PINS-1:0];
    else        own_q <= own_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gctl_q <= '0;
    else if (bus_we && sel == RG_GCTL)   gctl_q <= bus_wdata;
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_wsel
    assign wr_stat[w] = bus_we && sel == RG_STAT && word_idx == WIDX_W'(w);
    assign wr_en[w]   = bus_we && sel == RG_EN   && word_idx == WIDX_W'(w);
  end

  gpio_bitmap_bank #(.NUM_PINS(NUM_PINS), .CLEAR_ON_ONE(1'b1)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_word(wr_stat), .wdata(bus_wdata),
    .set_bits(irq_event), .q(stat_q)
  );

  gpio_bitmap_bank #(.NUM_PINS(NUM_PINS), .CLEAR_ON_ONE(1'b0)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_word(wr_en), .wdata(bus_wdata),
    .set_bits('0), .q(irq_en)
  );

  assign wcfg1 = unpack_cfg1(bus_wdata);
  assign wcfg2 = unpack_cfg2(bus_wdata);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    cfg1_t c1;
    cfg2_t c2;
    logic  wr1, wr2;
    assign wr1 = bus_we && sel == RG_CFG1 && pin_idx == PIN_W'(i);
    assign wr2 = bus_we && sel == RG_CFG2 && pin_idx == PIN_W'(i);
    gpio_pin_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .wr1(wr1), .wr2(wr2),
      .new1(wcfg1), .new2(wcfg2), .sync_in(sync_q[i]),
      .c1(c1), .c2(c2), .in_lvl(det_in[i]), .rd1(rd1[i]), .rd2(rd2[i])
    );
    assign pad_out[i]        = c1.out_lvl;
    assign pad_oe[i]         = c1.use_gpio & ~c1.dir_in;
    assign pin_use[i]        = c1.use_gpio;
    assign trig_level[i]     = c1.trig_lvl;
    assign trig_inv[i]       = c1.trig_inv;
    assign pin_pull[2*i +: 2] = c2.pull;
  end

  always_comb begin
    own_pad  = '0;
    stat_pad = '0;
    en_pad   = '0;
    own_pad[NUM_PINS-1:0]  = own_q;
    stat_pad[NUM_PINS-1:0] = stat_q;
    en_pad[NUM_PINS-1:0]   = irq_en;
  end

  always_comb begin
    unique case (sel)
      RG_OWN:  bus_rdata = own_pad[word_idx*WORD_W +: WORD_W];
      RG_GCTL: bus_rdata = gctl_q;
      RG_STAT: bus_rdata = stat_pad[word_idx*WORD_W +: WORD_W];
      RG_EN:   bus_rdata = en_pad[word_idx*WORD_W +: WORD_W];
      RG_CFG1: bus_rdata = rd1[pin_idx];
      RG_CFG2: bus_rdata = rd2[pin_idx];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NUM_PINS = 94
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] det_in,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pin_use,
  input logic [NUM_PINS-1:0] irq_event,
  input logic [NUM_PINS-1:0] stat_q,
  input logic [NUM_PINS-1:0] own_q,
  input logic                addr_hit,
  input logic [31:0]         bus_rdata
);
  p_own_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(own_q));

  p_det_two_flops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_in & ~$past(pad_in, 2)) == '0);

  p_oe_needs_gpio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~pin_use) == '0);

  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_event) & ~stat_q) == '0);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> bus_rdata == '0);
endmodule

bind gpio_bank_regs gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .det_in(det_in),
  .pad_oe(pad_oe), .pin_use(pin_use), .irq_event(irq_event),
  .stat_q(stat_q), .own_q(own_q), .addr_hit(addr_hit), .bus_rdata(bus_rdata)
);

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
  localparam int N = 40;
  localparam logic [127:0] OWN = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFC3_DEAD_BEEF;
  localparam logic [31:0] M1 = 32'h8000_001D;
  localparam logic [31:0] M2 = 32'h0000_0007;

  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe, pin_use, trig_level, trig_inv, irq_en, det_in;
  logic [N-1:0] irq_event = '0;
  logic [2*N-1:0] pin_pull;
  logic [31:0] gctl_q;

  gpio_bank_regs #(.NUM_PINS(N), .ADDR_W(12), .OWN_INIT(OWN)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_c1 [N];
  logic [31:0] m_c2 [N];
  logic [N-1:0] m_en, m_st;
  logic [31:0] m_gctl;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bm_word(logic [N-1:0] v, int w);
    logic [127:0] p = '0;
    p[N-1:0] = v;
    return p[w*32 +: 32];
  endfunction

  // expected read value from the requirement map
  function automatic logic [31:0] exp_read(int a);
    int pin;
    if (a % 4 != 0) return 0;
    if (a >= 'h100) begin
      pin = (a - 'h100) / 8;
      if (pin >= N) return 0;
      if (a % 8 == 0) return m_c1[pin] | {1'b0, pad_in[pin] & ~m_c2[pin][2], 30'b0};
      return m_c2[pin];
    end
    if (a == 'h7C) return m_gctl;
    if (a < 8) return (a == 0) ? OWN[31:0] : {24'b0, OWN[39:32]};
    if (a >= 'h80 && a < 'h88) return bm_word(m_st, (a - 'h80) / 4);
    if (a >= 'h90 && a < 'h98) return bm_word(m_en, (a - 'h90) / 4);
    return 0;
  endfunction

  function automatic void model_write(int a, logic [31:0] d);
    int pin;
    if (a % 4 != 0) return;
    if (a >= 'h100) begin
      pin = (a - 'h100) / 8;
      if (pin >= N) return;
      if (a % 8 == 0) m_c1[pin] = d & M1; else m_c2[pin] = d & M2;
    end else if (a == 'h7C) m_gctl = d;
    else if (a >= 'h80 && a < 'h88) begin
      for (int b = 0; b < 32; b++)
        if (d[b] && ((a - 'h80) / 4) * 32 + b < N) m_st[((a - 'h80) / 4) * 32 + b] = 1'b0;
    end else if (a >= 'h90 && a < 'h98) begin
      for (int b = 0; b < 32; b++)
        if (((a - 'h90) / 4) * 32 + b < N) m_en[((a - 'h90) / 4) * 32 + b] = d[b];
    end
  endfunction

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    model_write(a, d);
  endtask

  task automatic bus_read(int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 12'(a);
    #1 v = bus_rdata;
  endtask

  task automatic read_chk(string req, int a);
    logic [31:0] v;
    bus_read(a, v);
    chk(req, v, exp_read(a));
  endtask

  function automatic int rand_addr();
    int k = $urandom % 6;
    case (k)
      0: return ($urandom % 4) * 4;
      1: return 'h7C;
      2: return 'h80 + ($urandom % 3) * 4;
      3: return 'h90 + ($urandom % 3) * 4;
      4: return 'h100 + ($urandom % (N + 2)) * 8 + ($urandom % 2) * 4;
      default: return $urandom % 4096;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N; i++) begin m_c1[i] = 32'h4; m_c2[i] = 32'h4; end
    m_en = '0; m_st = '0; m_gctl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // reset state
    read_chk("R4 reset cfg1", 'h100);
    read_chk("R5 reset cfg2", 'h104 + 8*39);
    read_chk("R1 own word0", 'h00);
    read_chk("R1 own word1 partial", 'h04);
    read_chk("R9 own word past bank", 'h08);
    read_chk("R3 enable reset", 'h94);
    read_chk("R2 gctl reset", 'h7C);
    chk("R7 oe reset", 32'(pad_oe), 0);

    // R7 output enable gating
    bus_write('h100 + 8*3, 32'h8000_0001);
    chk("R7 oe gpio out", 32'(pad_oe[3]), 1);
    chk("R7 pad_out", 32'(pad_out[3]), 1);
    bus_write('h100 + 8*3, 32'h8000_0000);
    chk("R7 oe native", 32'(pad_oe[3]), 0);
    bus_write('h100 + 8*3, 32'h8000_0005);
    chk("R7 oe input dir", 32'(pad_oe[3]), 0);

    // R6 two-flop latency, bit30 write ignored, sense gating
    bus_write('h104 + 8*5, 32'h0);
    bus_write('h100 + 8*5, 32'h4000_0004);
    read_chk("R6 bit30 write ignored", 'h100 + 8*5);
    @(negedge clk);
    pad_in[5] = 1; bus_addr = 12'('h100 + 8*5);
    @(negedge clk); #1;
    chk("R6 one flop not yet", bus_rdata, 32'h4);
    @(negedge clk); #1;
    chk("R6 after two flops", bus_rdata, 32'h4000_0004);
    chk("R6 det_in enabled", 32'(det_in[5]), 1);
    bus_write('h104 + 8*5, 32'h4);
    read_chk("R6 sense disabled reads 0", 'h100 + 8*5);
    chk("R6 det_in gated", 32'(det_in[5]), 0);

    // R8 status set, clear, race
    @(negedge clk) irq_event[33] = 1;
    @(negedge clk) irq_event[33] = 0;
    m_st[33] = 1;
    read_chk("R8 event sets status", 'h84);
    bus_write('h84, 32'h2);
    read_chk("R8 write one clears", 'h84);
    @(negedge clk);
    bus_addr = 12'h84; bus_wdata = 32'h2; bus_we = 1; irq_event[33] = 1;
    @(negedge clk);
    bus_we = 0; irq_event[33] = 0;
    m_st[33] = 1;
    read_chk("R8 set wins over clear", 'h84);

    // R9 out-of-range and R1 read-only
    bus_write('h100 + 8*N, 32'hFFFF_FFFF);
    read_chk("R9 pin at count reads 0", 'h100 + 8*N);
    read_chk("R9 last pin untouched", 'h100 + 8*(N-1));
    bus_write('h00, 32'h0);
    read_chk("R1 own ignores write", 'h00);
    bus_write('h92, 32'hFFFF_FFFF);
    read_chk("R9 misaligned write ignored", 'h90);

    // random phase with pads held
    @(negedge clk) pad_in = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    for (int it = 0; it < 400; it++) begin
      bus_write(rand_addr(), $urandom);
      read_chk("R1-map random readback R2 R3 R4 R5 R6 R9", rand_addr());
    end

    // exported fields vs model
    for (int i = 0; i < N; i++) begin
      chk("R7 exports", {pad_out[i], pad_oe[i], pin_use[i], trig_level[i], trig_inv[i], pin_pull[2*i +: 2]},
          {m_c1[i][31], m_c1[i][0] & ~m_c1[i][2], m_c1[i][0], m_c1[i][4], m_c1[i][3], m_c2[i][1:0]});
      chk("R3 irq_en", 32'(irq_en[i]), 32'(m_en[i]));
      chk("R6 det_in", 32'(det_in[i]), 32'(pad_in[i] & ~m_c2[i][2]));
    end
    chk("R2 gctl port", gctl_q, m_gctl);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule